// File: doc/BRIEF.md
# RTC Status Flag Register

This block is the status register of a real-time clock. It keeps five flags in one byte: total power failure, oscillator halted, alarm matched, daylight-saving shift applied, and main supply low. The timekeeping core sends it single-cycle events: alarm match, DST forward and DST reverse, power-up after total loss, and writes to the time registers. It also sends level signals: oscillator stopped, DST enabled, auto-clear enabled, running on the main supply, and the supply comparator output. Software reads the byte through a combinational read port and writes it through a byte write port.

Each flag has its own rule for setting and clearing. Alarm and oscillator flags are sticky and a write can only clear them. The power-fail flag cannot be written; the first write to any time register clears it. The DST flag follows the forward and reverse events and is forced low while DST is disabled. The supply flag follows a synchronised comparator level while the clock runs from the main supply. When a set event and a clear arrive in the same cycle, the flag ends up set.

Bit map (byte read on `reg_rdata`, written on `reg_wdata`): bit 0 power fail, bit 1 oscillator halted, bit 2 alarm, bit 3 DST applied, bit 4 main supply low, bits 7:5 always 0.

Top module: `rtc_stat_reg`

## Requirements
- R1: A cycle with `alarm_hit` high makes bit 2 read 1 from the next cycle on.
- R2: A register write with `reg_wdata[2]`=0 clears bit 2 in the next cycle. A write with `reg_wdata[2]`=1 leaves bit 2 unchanged, so a write never sets it.
- R3: A cycle with `reg_rd` and `auto_clr_en` both high clears bit 2 afterwards, unless `alarm_hit` is also high in that cycle; then bit 2 stays 1. A read with `auto_clr_en` low leaves bit 2 unchanged.
- R4: Bit 0 is set by a `pwr_boot` pulse. Supply-mode changes and register writes never set it.
- R5: A `tk_wr` pulse clears bit 0 in the next cycle. A status register write leaves bit 0 unchanged.
- R6: With `dst_en` high: `dst_fwd` sets bit 3, `dst_rev` clears it, and otherwise it holds. A register write loads `reg_wdata[3]` into it. An event in the same cycle takes priority over the write, and forward takes priority over reverse.
- R7: While `dst_en` is low, bit 3 reads 0 from the next cycle on, whatever events or writes arrive.
- R8: Bit 4 equals `on_main` of the previous cycle ANDed with `vdd_low` of SYNC_STAGES+1 cycles earlier. Running on battery (`on_main`=0) gives 0.
- R9: Bit 1 is set in every cycle that `osc_stop` is high. It stays 1 until a register write with `reg_wdata[1]`=0.
- R10: A set event in the same cycle as a clearing write or strobe leaves the flag at 1. This applies to the alarm, oscillator and power-fail flags.
- R11: After reset all bits read 0, and bits 7:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Status register write strobe |
| reg_rd | input | 1 | Status register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current status byte |
| tk_wr | input | 1 | Write to any time register (pulse) |
| alarm_hit | input | 1 | Alarm compare match (pulse) |
| dst_fwd | input | 1 | DST forward event (pulse) |
| dst_rev | input | 1 | DST reverse event (pulse) |
| dst_en | input | 1 | DST enabled level |
| auto_clr_en | input | 1 | Clear alarm flag on read |
| osc_stop | input | 1 | Oscillator stopped level |
| pwr_boot | input | 1 | Power-up after total supply loss (pulse) |
| on_main | input | 1 | 1 while running from the main supply |
| vdd_low | input | 1 | Main supply comparator, 1 = below trip level (asynchronous) |

## Verification
The assertions assume that every input except `vdd_low` is synchronous to `clk` and valid from the first edge after reset. They also assume that `vdd_low` is only ever seen through the synchroniser. The bench drives all inputs on the falling edge, so every input is stable at the rising edge. It picks random values that often put set events and clearing writes, reads or time-register writes in the same cycle. It also toggles `dst_en` and `on_main` in the middle of event sequences, so the priority rules are exercised in every combination.

// File: rtl/rtc_stat_pkg.sv
// Shared bit positions and sizes of the RTC status byte.
// Assumes an 8-bit register port; bits above the flags read as zero.
package rtc_stat_pkg;
    localparam int STAT_W   = 8;
    localparam int B_PWRF   = 0;
    localparam int B_OSC    = 1;
    localparam int B_ALM    = 2;
    localparam int B_DST    = 3;
    localparam int B_MLOW   = 4;
    localparam int N_FLAGS  = 5;
    localparam int N_STICKY = 3;

    // Map a sticky-flag index (0..N_STICKY-1) to its bit in the status byte.
    function automatic int sticky_bit(input int idx);
        case (idx)
            0:       return B_PWRF;
            1:       return B_OSC;
            default: return B_ALM;
        endcase
    endfunction
endpackage

// File: rtl/stat_sticky_bit.sv
// One sticky flag: a set request wins over a clear request in the same cycle.
// Assumes set_i and clr_i are synchronous to clk.
module stat_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold the flag; set has priority, clear next, otherwise keep.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/stat_dst_bit.sv
// DST-applied flag: forward sets, reverse clears, and a write loads it when no
// event arrives. DST disabled forces it low and takes priority over everything.
// Assumes the events are single-cycle pulses from the timekeeping core.
module stat_dst_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fwd_i,
    input  logic rev_i,
    input  logic wr_i,
    input  logic wd_i,
    output logic q_o
);
    logic nxt;

    // Choose the next value by priority: disable, forward, reverse, write.
    always_comb begin
        nxt = q_o;
        if (!en_i)      nxt = 1'b0;
        else if (fwd_i) nxt = 1'b1;
        else if (rev_i) nxt = 1'b0;
        else if (wr_i)  nxt = wd_i;
    end

    // Register the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= nxt;
    end
endmodule

// File: rtl/stat_lvl_sync.sv
// Brings an asynchronous comparator level through a STAGES-deep flop chain and
// registers it gated by a synchronous enable. Latency from lvl_i is STAGES+1.
// Assumes STAGES >= 1.
module stat_lvl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic lvl_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First synchroniser flop samples the raw level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= lvl_i;
                end
            end else begin : g_next
                // Later flops shift the level along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Flag register: the level counts only while the enable is high.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= gate_i & chain[STAGES-1];
    end
endmodule

// File: rtl/rtc_stat_reg.sv
// RTC status flag register. Combines three sticky flags (power fail,
// oscillator halted, alarm), the DST-applied flag and a synchronised
// main-supply-low flag into one readable byte.
// Assumes all inputs but vdd_low are synchronous to clk.
module rtc_stat_reg
    import rtc_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    input  logic              tk_wr,
    input  logic              alarm_hit,
    input  logic              dst_fwd,
    input  logic              dst_rev,
    input  logic              dst_en,
    input  logic              auto_clr_en,
    input  logic              osc_stop,
    input  logic              pwr_boot,
    input  logic              on_main,
    input  logic              vdd_low
);
    localparam int PAD_W = STAT_W - N_FLAGS;

    logic [N_STICKY-1:0] sk_set;
    logic [N_STICKY-1:0] sk_clr;
    logic [N_STICKY-1:0] sk_q;
    logic                dst_q;
    logic                mlow_q;

    // Set and clear requests for each sticky flag.
    always_comb begin
        sk_set[0] = pwr_boot;
        sk_clr[0] = tk_wr;
        sk_set[1] = osc_stop;
        sk_clr[1] = reg_wr & ~reg_wdata[B_OSC];
        sk_set[2] = alarm_hit;
        sk_clr[2] = (reg_wr & ~reg_wdata[B_ALM]) | (reg_rd & auto_clr_en);
    end

    genvar i;
    generate
        for (i = 0; i < N_STICKY; i++) begin : g_sticky
            stat_sticky_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (sk_set[i]),
                .clr_i (sk_clr[i]),
                .q_o   (sk_q[i])
            );
        end
    endgenerate

    stat_dst_bit u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (dst_en),
        .fwd_i (dst_fwd),
        .rev_i (dst_rev),
        .wr_i  (reg_wr),
        .wd_i  (reg_wdata[B_DST]),
        .q_o   (dst_q)
    );

    stat_lvl_sync #(.STAGES(SYNC_STAGES)) u_mlow (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_i (on_main),
        .lvl_i  (vdd_low),
        .q_o    (mlow_q)
    );

    // Assemble the readable status byte.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_STICKY; k++) reg_rdata[sticky_bit(k)] = sk_q[k];
        reg_rdata[B_DST]  = dst_q;
        reg_rdata[B_MLOW] = mlow_q;
        reg_rdata[STAT_W-1 -: PAD_W] = '0;
    end
endmodule

// File: rtl/rtc_stat_reg_chk.sv
// Checker for rtc_stat_reg: relates event inputs to the status byte over time.
// Assumes inputs are synchronous to clk and rst_n is low at time zero.
module rtc_stat_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tk_wr,
    input logic       alarm_hit,
    input logic       dst_fwd,
    input logic       dst_en,
    input logic       auto_clr_en,
    input logic       osc_stop,
    input logic       pwr_boot,
    input logic       on_main
);
    p_alarm_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> reg_rdata[2]);
    p_no_wr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[2] && !alarm_hit) |=> !reg_rdata[2]);
    p_autoclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && auto_clr_en && !alarm_hit) |=> !reg_rdata[2]);
    p_pwrf_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[0] && !pwr_boot) |=> !reg_rdata[0]);
    p_pwrf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_wr && !pwr_boot) |=> !reg_rdata[0]);
    p_dst_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_en && dst_fwd) |=> reg_rdata[3]);
    p_dst_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_en |=> !reg_rdata[3]);
    p_batt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !on_main |=> !reg_rdata[4]);
    p_osc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !(reg_wr && !reg_wdata[1])) |=> reg_rdata[1]);
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && reg_wr && !reg_wdata[1]) |=> reg_rdata[1]);
    p_rst_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 8'h00));
endmodule

bind rtc_stat_reg rtc_stat_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .tk_wr       (tk_wr),
    .alarm_hit   (alarm_hit),
    .dst_fwd     (dst_fwd),
    .dst_en      (dst_en),
    .auto_clr_en (auto_clr_en),
    .osc_stop    (osc_stop),
    .pwr_boot    (pwr_boot),
    .on_main     (on_main)
);

// File: tb/sim_rtc_stat_reg.sv
// Bench for rtc_stat_reg: directed cases then random traffic, compared every
// clock against a behavioural model of the requirements.
module sim_rtc_stat_reg;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0, tk_wr = 0, alarm_hit = 0;
    logic       dst_fwd = 0, dst_rev = 0, dst_en = 0, auto_clr_en = 0;
    logic       osc_stop = 0, pwr_boot = 0, on_main = 0, vdd_low = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    rtc_stat_reg #(.SYNC_STAGES(SYNC)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural model state.
    bit m_pf, m_osc, m_alm, m_dst, m_low;
    bit hist[$];

    // Model update at each rising edge, from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pf = 0; m_osc = 0; m_alm = 0; m_dst = 0; m_low = 0;
            hist = {};
            for (int k = 0; k < SYNC; k++) hist.push_back(1'b0);
        end else begin
            if (reg_wr && !reg_wdata[2]) m_alm = 0;
            if (reg_rd && auto_clr_en) m_alm = 0;
            if (alarm_hit) m_alm = 1;
            if (reg_wr && !reg_wdata[1]) m_osc = 0;
            if (osc_stop) m_osc = 1;
            if (tk_wr) m_pf = 0;
            if (pwr_boot) m_pf = 1;
            if (reg_wr) m_dst = reg_wdata[3];
            if (dst_rev) m_dst = 0;
            if (dst_fwd) m_dst = 1;
            if (!dst_en) m_dst = 0;
            m_low = on_main & hist[0];
            hist.push_back(vdd_low);
            void'(hist.pop_front());
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every field against the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4/R5 power-fail bit", {7'd0, reg_rdata[0]}, {7'd0, m_pf});
            check("R9 oscillator bit",    {7'd0, reg_rdata[1]}, {7'd0, m_osc});
            check("R1/R2/R3 alarm bit",   {7'd0, reg_rdata[2]}, {7'd0, m_alm});
            check("R6/R7 dst bit",        {7'd0, reg_rdata[3]}, {7'd0, m_dst});
            check("R8 supply-low bit",    {7'd0, reg_rdata[4]}, {7'd0, m_low});
            check("R11 unused bits",      {5'd0, reg_rdata[7:5]}, 8'h00);
        end
    end

    // Advance one clock and drop the single-cycle strobes.
    task automatic step();
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; tk_wr = 0; alarm_hit = 0;
        dst_fwd = 0; dst_rev = 0; pwr_boot = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        check("R11 reset state", reg_rdata, 8'h00);

        alarm_hit = 1; step();
        check("R1 alarm sets", reg_rdata & 8'h04, 8'h04);
        reg_wr = 1; reg_wdata = 8'hFF; step();
        check("R2 write 1 keeps alarm", reg_rdata & 8'h04, 8'h04);
        reg_wr = 1; reg_wdata = 8'h00; step();
        check("R2 write 0 clears alarm", reg_rdata & 8'h04, 8'h00);
        reg_wr = 1; reg_wdata = 8'h04; step();
        check("R2 write cannot set alarm", reg_rdata & 8'h04, 8'h00);

        alarm_hit = 1; step();
        auto_clr_en = 1; reg_rd = 1; alarm_hit = 1; step();
        check("R3 alarm during read survives", reg_rdata & 8'h04, 8'h04);
        reg_rd = 1; step();
        check("R3 read auto-clears alarm", reg_rdata & 8'h04, 8'h00);
        auto_clr_en = 0;

        on_main = 1; step(); on_main = 0; step();
        check("R4 supply change does not set power-fail", reg_rdata & 8'h01, 8'h00);
        pwr_boot = 1; step();
        check("R4 boot sets power-fail", reg_rdata & 8'h01, 8'h01);
        reg_wr = 1; reg_wdata = 8'h00; step();
        check("R5 status write keeps power-fail", reg_rdata & 8'h01, 8'h01);
        tk_wr = 1; step();
        check("R5 time write clears power-fail", reg_rdata & 8'h01, 8'h00);
        tk_wr = 1; pwr_boot = 1; step();
        check("R10 boot beats time write", reg_rdata & 8'h01, 8'h01);

        dst_en = 1; dst_fwd = 1; step();
        check("R6 forward sets dst", reg_rdata & 8'h08, 8'h08);
        dst_fwd = 1; step();
        check("R6 second forward holds dst", reg_rdata & 8'h08, 8'h08);
        dst_rev = 1; step();
        check("R6 reverse clears dst", reg_rdata & 8'h08, 8'h00);
        reg_wr = 1; reg_wdata = 8'h08; step();
        check("R6 write loads dst", reg_rdata & 8'h08, 8'h08);
        dst_en = 0; dst_fwd = 1; step();
        check("R7 disable forces dst low", reg_rdata & 8'h08, 8'h00);

        on_main = 1; vdd_low = 1; step(); step();
        check("R8 low not yet through sync", reg_rdata & 8'h10, 8'h00);
        step();
        check("R8 low seen after SYNC+1", reg_rdata & 8'h10, 8'h10);
        on_main = 0; step();
        check("R8 battery mode hides low", reg_rdata & 8'h10, 8'h00);
        vdd_low = 0;

        osc_stop = 1; step(); osc_stop = 0; step();
        check("R9 oscillator flag sticky", reg_rdata & 8'h02, 8'h02);
        osc_stop = 1; reg_wr = 1; reg_wdata = 8'h00; step(); osc_stop = 0;
        check("R10 stop beats clearing write", reg_rdata & 8'h02, 8'h02);
        reg_wr = 1; reg_wdata = 8'h00; step();
        check("R9 write 0 clears oscillator flag", reg_rdata & 8'h02, 8'h00);

        for (int c = 0; c < 4000; c++) begin
            reg_wr      = ($urandom % 4) == 0;
            reg_wdata   = 8'($urandom);
            reg_rd      = ($urandom % 3) == 0;
            tk_wr       = ($urandom % 6) == 0;
            alarm_hit   = ($urandom % 5) == 0;
            dst_fwd     = ($urandom % 6) == 0;
            dst_rev     = ($urandom % 6) == 0;
            pwr_boot    = ($urandom % 9) == 0;
            osc_stop    = ($urandom % 7) == 0;
            vdd_low     = ($urandom % 2) == 0;
            if (($urandom % 10) == 0) dst_en = ~dst_en;
            if (($urandom % 10) == 0) on_main = ~on_main;
            if (($urandom % 15) == 0) auto_clr_en = ~auto_clr_en;
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule